// File: doc/BRIEF.md
# Constant-Time Random Permutation Generator

This block produces a random ordering of the integers 0 to 2^IDX_W − 1. It does not shuffle by rejection sampling. Instead it pairs every index with a random key and sorts the pairs by key. The order in which the indices come out of the sort is the permutation.

The keys come from a 64-bit xorshift generator. They are written into one of two equal banks. A bottom-up merge sort then moves the data back and forth between the two banks, one pass at a time. Each pass doubles the length of the sorted runs. The schedule of reads and writes depends only on the parameters and never on the key values. As a result, the number of cycles from start to the first output is the same for every seed.

A host uses the block in this order:

1. Load a seed.
2. Pulse `start`.
3. Drain the indices from a valid/ready stream.

The stream follows these rules:

- While `perm_valid` is high and `perm_ready` is low, the block holds the current index and `perm_last` stable.
- One index is consumed on each clock edge where both `perm_valid` and `perm_ready` are high.
- `perm_valid` never drops until the last index has been taken.

Top module: `perm_sort_gen`

## Requirements
- R1: After reset, `busy`, `done`, `tie_seen` and `perm_valid` are all 0.
- R2: `seed_load`, when sampled while idle, replaces the generator state with `seed_value`. A zero seed is replaced by 64'h9E3779B97F4A7C15. One xorshift step computes s ^= s<<13, then s ^= s>>7, then s ^= s<<17. The key of index i is the low KEY_W bits of the (i+1)-th step after the current state. A later `start` without a new seed continues from the state the previous run left behind.
- R3: The stream carries the indices 0..2^IDX_W−1, each exactly once, in ascending key order. Equal keys keep ascending index order, so the sort is stable.
- R4: The number of cycles from an accepted `start` to the first `perm_valid` is identical for every seed.
- R5: While `perm_valid`=1 and `perm_ready`=0, `perm_valid` stays 1 and `perm_index` and `perm_last` do not change. Exactly 2^IDX_W handshakes occur, and `perm_last` is 1 only on the final one.
- R6: On the cycle after the final handshake, `done`=1, `busy`=0 and `perm_valid`=0. `done` stays 1 until the next accepted `start`.
- R7: While `busy`=1, `start` and `seed_load` have no effect: the run in progress yields the same indices and the same cycle count.
- R8: `tie_seen` becomes 1 if two consecutively emitted entries had equal keys. It is cleared by an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed_value` into the generator (idle only) |
| seed_value | input | 64 | Generator seed |
| start | input | 1 | Begin fill, sort and emit (idle only) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has fully drained |
| tie_seen | output | 1 | Equal adjacent keys occurred in the last run |
| perm_valid | output | 1 | `perm_index` holds a valid index |
| perm_ready | input | 1 | The consumer accepts `perm_index` |
| perm_index | output | IDX_W | Next index of the permutation |
| perm_last | output | 1 | The current index is the final one |

## Verification
The hardest case to reach from the ports is a merge that must decide between equal keys while the other run is still non-empty. With 32-bit keys this almost never happens. The bench therefore narrows the key to 8 bits over 32 entries, so ties appear in most seeds. Every emitted index is then compared against a stable software sort of the same xorshift keys.

Back-pressure is applied through per-seed ready patterns. A `start` and a seed load are also injected in the middle of a sort. These show that the timing and the order of a run are unaffected by such inputs.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FILL,
    PH_SORT,
    PH_EMIT
  } phase_t;

  localparam logic [63:0] SEED_SUBST = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [63:0] xs_step(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

endpackage

// File: rtl/perm_xorshift.sv
module perm_xorshift
  import perm_pkg::*;
#(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [63:0]      seed,
  input  logic             advance,
  output logic [KEY_W-1:0] key
);

  logic [63:0] state_q;
  logic [63:0] next_s;

  assign next_s = xs_step(state_q);
  assign key    = next_s[KEY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED_SUBST;
    end else if (load) begin
      state_q <= (seed == 64'd0) ? SEED_SUBST : seed;
    end else if (advance) begin
      state_q <= next_s;
    end
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 64'd0); // R2

endmodule

// File: rtl/perm_bank.sv
module perm_bank #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 38
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WORD_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra_a,
  input  logic [ADDR_W-1:0] ra_b,
  output logic [WORD_W-1:0] rd_a,
  output logic [WORD_W-1:0] rd_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

endmodule

// File: rtl/perm_merge_engine.sv
module perm_merge_engine #(
  parameter int IDX_W  = 6,
  parameter int KEY_W  = 32,
  parameter int PASS_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pass_start,
  input  logic [PASS_W-1:0]        pass_idx,
  output logic [IDX_W-1:0]         rd_addr_a,
  output logic [IDX_W-1:0]         rd_addr_b,
  input  logic [KEY_W+IDX_W-1:0]   rd_word_a,
  input  logic [KEY_W+IDX_W-1:0]   rd_word_b,
  output logic                     wr_en,
  output logic [IDX_W-1:0]         wr_addr,
  output logic [KEY_W+IDX_W-1:0]   wr_word,
  output logic                     pass_done
);

  localparam int WORD_W = KEY_W + IDX_W;
  localparam int LANE_W = 2;
  localparam int LANES  = 1 << LANE_W;
  localparam int CNT_W  = IDX_W + 1;
  localparam int BASE_W = IDX_W + LANE_W + 2;

  logic [CNT_W-1:0]  run_len;
  logic [BASE_W-1:0] span, stride, n_total;

  assign run_len = CNT_W'(1) << pass_idx;
  assign span    = BASE_W'(run_len) << 1;
  assign stride  = span << LANE_W;
  assign n_total = BASE_W'(1) << IDX_W;

  // per-lane merge cursors
  logic [BASE_W-1:0] ln_base [LANES];
  logic [CNT_W-1:0]  ln_li   [LANES];
  logic [CNT_W-1:0]  ln_ri   [LANES];
  logic [LANES-1:0]  ln_act;
  logic              running;
  logic [LANE_W-1:0] rr;

  // stage 1: issued addresses
  logic              s1_v;
  logic [LANE_W-1:0] s1_lane;
  logic [BASE_W-1:0] s1_base;
  logic [CNT_W-1:0]  s1_li, s1_ri;
  // stage 2: captured words
  logic              s2_v;
  logic [LANE_W-1:0] s2_lane;
  logic [BASE_W-1:0] s2_base;
  logic [CNT_W-1:0]  s2_li, s2_ri;
  logic [WORD_W-1:0] s2_wa, s2_wb;
  // stage 3: write back
  logic              s3_v;
  logic [IDX_W-1:0]  s3_addr;
  logic [WORD_W-1:0] s3_word;

  logic iss_v;
  assign iss_v = running && ln_act[rr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_lane <= '0;
      s1_base <= '0;
      s1_li   <= '0;
      s1_ri   <= '0;
    end else begin
      s1_v    <= iss_v;
      s1_lane <= rr;
      s1_base <= ln_base[rr];
      s1_li   <= ln_li[rr];
      s1_ri   <= ln_ri[rr];
    end
  end

  assign rd_addr_a = IDX_W'(s1_base + BASE_W'(s1_li));
  assign rd_addr_b = IDX_W'(s1_base + BASE_W'(run_len) + BASE_W'(s1_ri));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_lane <= '0;
      s2_base <= '0;
      s2_li   <= '0;
      s2_ri   <= '0;
      s2_wa   <= '0;
      s2_wb   <= '0;
    end else begin
      s2_v    <= s1_v;
      s2_lane <= s1_lane;
      s2_base <= s1_base;
      s2_li   <= s1_li;
      s2_ri   <= s1_ri;
      s2_wa   <= rd_word_a;
      s2_wb   <= rd_word_b;
    end
  end

  // stage 2 compare: ties favour the left run (stable)
  logic             left_empty, right_empty, take_left;
  logic [KEY_W-1:0] key_a, key_b;
  logic [CNT_W-1:0] nxt_li, nxt_ri;
  logic             merge_end;

  assign key_a       = s2_wa[WORD_W-1:IDX_W];
  assign key_b       = s2_wb[WORD_W-1:IDX_W];
  assign left_empty  = (s2_li == run_len);
  assign right_empty = (s2_ri == run_len);
  assign take_left   = right_empty || (!left_empty && !(key_b < key_a));
  assign nxt_li      = s2_li + CNT_W'(take_left);
  assign nxt_ri      = s2_ri + CNT_W'(!take_left);
  assign merge_end   = (BASE_W'(nxt_li) + BASE_W'(nxt_ri)) == span;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_v    <= 1'b0;
      s3_addr <= '0;
      s3_word <= '0;
    end else begin
      s3_v    <= s2_v;
      s3_addr <= IDX_W'(s2_base + BASE_W'(s2_li) + BASE_W'(s2_ri));
      s3_word <= take_left ? s2_wa : s2_wb;
    end
  end

  assign wr_en   = s3_v;
  assign wr_addr = s3_addr;
  assign wr_word = s3_word;

  logic pipe_empty;
  assign pipe_empty = !s1_v && !s2_v && !s3_v;
  assign pass_done  = running && (ln_act == '0) && pipe_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      rr      <= '0;
      ln_act  <= '0;
      for (int k = 0; k < LANES; k++) begin
        ln_base[k] <= '0;
        ln_li[k]   <= '0;
        ln_ri[k]   <= '0;
      end
    end else if (pass_start) begin
      running <= 1'b1;
      rr      <= '0;
      for (int k = 0; k < LANES; k++) begin
        ln_base[k] <= BASE_W'(k) * span;
        ln_li[k]   <= '0;
        ln_ri[k]   <= '0;
        ln_act[k]  <= (BASE_W'(k) * span) < n_total;
      end
    end else begin
      if (running) rr <= rr + 1'b1;
      if (s2_v) begin
        if (merge_end) begin
          ln_base[s2_lane] <= ln_base[s2_lane] + stride;
          ln_li[s2_lane]   <= '0;
          ln_ri[s2_lane]   <= '0;
          ln_act[s2_lane]  <= (ln_base[s2_lane] + stride) < n_total;
        end else begin
          ln_li[s2_lane] <= nxt_li;
          ln_ri[s2_lane] <= nxt_ri;
        end
      end
      if (pass_done) running <= 1'b0;
    end
  end

  AST_MERGE_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |-> !(left_empty && right_empty)); // R3

  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    s3_v |-> running); // R4

endmodule

// File: rtl/perm_sort_gen.sv
module perm_sort_gen
  import perm_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [63:0]      seed_value,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             tie_seen,
  output logic             perm_valid,
  input  logic             perm_ready,
  output logic [IDX_W-1:0] perm_index,
  output logic             perm_last
);

  localparam int WORD_W = KEY_W + IDX_W;
  localparam int PASS_W = (IDX_W < 2) ? 1 : $clog2(IDX_W);

  phase_t            phase;
  logic [IDX_W-1:0]  fill_ptr, emit_ptr;
  logic [PASS_W-1:0] pass_idx;
  logic              src_sel, kick, done_q, tie_q;
  logic [KEY_W-1:0]  prev_key;

  logic [KEY_W-1:0]  rnd_key;
  logic              fill_we;

  assign fill_we = (phase == PH_FILL);

  perm_xorshift #(.KEY_W(KEY_W)) rng_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (seed_load && (phase == PH_IDLE)),
    .seed    (seed_value),
    .advance (fill_we),
    .key     (rnd_key)
  );

  logic [IDX_W-1:0]  eng_ra, eng_rb, eng_wa;
  logic [WORD_W-1:0] eng_da, eng_db, eng_wd;
  logic              eng_we, eng_done;

  perm_merge_engine #(.IDX_W(IDX_W), .KEY_W(KEY_W), .PASS_W(PASS_W)) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass_start (kick),
    .pass_idx   (pass_idx),
    .rd_addr_a  (eng_ra),
    .rd_addr_b  (eng_rb),
    .rd_word_a  (eng_da),
    .rd_word_b  (eng_db),
    .wr_en      (eng_we),
    .wr_addr    (eng_wa),
    .wr_word    (eng_wd),
    .pass_done  (eng_done)
  );

  logic [WORD_W-1:0] bank_rda [2];
  logic [WORD_W-1:0] bank_rdb [2];
  logic [IDX_W-1:0]  rd_port_a;

  assign rd_port_a = (phase == PH_EMIT) ? emit_ptr : eng_ra;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic              we_g;
    logic [IDX_W-1:0]  wa_g;
    logic [WORD_W-1:0] wd_g;
    if (g == 0) begin : g_fill
      assign we_g = fill_we || (eng_we && src_sel);
      assign wa_g = fill_we ? fill_ptr : eng_wa;
      assign wd_g = fill_we ? {rnd_key, fill_ptr} : eng_wd;
    end else begin : g_other
      assign we_g = eng_we && !src_sel;
      assign wa_g = eng_wa;
      assign wd_g = eng_wd;
    end
    perm_bank #(.ADDR_W(IDX_W), .WORD_W(WORD_W)) bank_i (
      .clk  (clk),
      .we   (we_g),
      .wa   (wa_g),
      .wd   (wd_g),
      .ra_a (rd_port_a),
      .ra_b (eng_rb),
      .rd_a (bank_rda[g]),
      .rd_b (bank_rdb[g])
    );
  end

  assign eng_da = src_sel ? bank_rda[1] : bank_rda[0];
  assign eng_db = src_sel ? bank_rdb[1] : bank_rdb[0];

  logic [KEY_W-1:0] cur_key;
  logic             hs;

  assign cur_key    = eng_da[WORD_W-1:IDX_W];
  assign perm_index = eng_da[IDX_W-1:0];
  assign perm_valid = (phase == PH_EMIT);
  assign perm_last  = perm_valid && (emit_ptr == '1);
  assign hs         = perm_valid && perm_ready;
  assign busy       = (phase != PH_IDLE);
  assign done       = done_q;
  assign tie_seen   = tie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      fill_ptr <= '0;
      emit_ptr <= '0;
      pass_idx <= '0;
      src_sel  <= 1'b0;
      kick     <= 1'b0;
      done_q   <= 1'b0;
      tie_q    <= 1'b0;
      prev_key <= '0;
    end else begin
      kick <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_FILL;
            fill_ptr <= '0;
            done_q   <= 1'b0;
            tie_q    <= 1'b0;
          end
        end
        PH_FILL: begin
          fill_ptr <= fill_ptr + 1'b1;
          if (fill_ptr == '1) begin
            phase    <= PH_SORT;
            pass_idx <= '0;
            src_sel  <= 1'b0;
            kick     <= 1'b1;
          end
        end
        PH_SORT: begin
          if (eng_done) begin
            src_sel <= ~src_sel;
            if (pass_idx == PASS_W'(IDX_W - 1)) begin
              phase    <= PH_EMIT;
              emit_ptr <= '0;
            end else begin
              pass_idx <= pass_idx + 1'b1;
              kick     <= 1'b1;
            end
          end
        end
        PH_EMIT: begin
          if (hs) begin
            prev_key <= cur_key;
            if ((emit_ptr != '0) && (cur_key == prev_key)) tie_q <= 1'b1;
            if (emit_ptr == '1) begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              emit_ptr <= emit_ptr + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    perm_valid && !perm_ready |=> perm_valid && $stable(perm_index) && $stable(perm_last)); // R5

  AST_EMIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    hs && (emit_ptr != '0) |-> !(cur_key < prev_key)); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(hs && perm_last)); // R6

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(hs && perm_last) |=> busy); // R7

endmodule

// File: tb/perm_sort_gen_tb.sv
module perm_sort_gen_tb_top;

  localparam int IDX_W = 5;
  localparam int KEY_W = 8;
  localparam int N     = 1 << IDX_W;
  localparam logic [63:0] SUBST = 64'h9E37_79B9_7F4A_7C15;

  localparam int NVEC = 5;
  localparam logic [63:0] SEED_TAB [NVEC] = '{
    64'h0000_0000_0000_0001, 64'hDEAD_BEEF_0123_4567, 64'h1357_9BDF_2468_ACE0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_1E1E_2D2D_3C3C };
  localparam logic [7:0] STALL_TAB [NVEC] = '{
    8'h00, 8'hAA, 8'h6D, 8'h01, 8'h7E };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic [63:0] seed_value = '0;
  logic start = 1'b0;
  logic perm_ready = 1'b0;
  logic busy, done, tie_seen, perm_valid, perm_last;
  logic [IDX_W-1:0] perm_index;

  always #5 clk = ~clk;

  perm_sort_gen #(.IDX_W(IDX_W), .KEY_W(KEY_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .tie_seen   (tie_seen),
    .perm_valid (perm_valid),
    .perm_ready (perm_ready),
    .perm_index (perm_index),
    .perm_last  (perm_last)
  );

  int checks = 0;
  int errors = 0;
  int ref_cycles = -1;
  longint unsigned cyc_total = 0;

  logic [63:0]      m_state;
  logic [KEY_W-1:0] mk [N];
  int               mi [N];
  bit               m_tie;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
      finish_all();
    end
  end

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  // R2/R3 model: keys from xorshift, stable sort by key
  task automatic model_run();
    for (int i = 0; i < N; i++) begin
      m_state = xs(m_state);
      mk[i] = m_state[KEY_W-1:0];
      mi[i] = i;
    end
    for (int i = 1; i < N; i++) begin
      int j;
      j = i;
      while (j > 0 && mk[j-1] > mk[j]) begin
        logic [KEY_W-1:0] tk;
        int ti;
        tk = mk[j]; mk[j] = mk[j-1]; mk[j-1] = tk;
        ti = mi[j]; mi[j] = mi[j-1]; mi[j-1] = ti;
        j--;
      end
    end
    m_tie = 1'b0;
    for (int i = 1; i < N; i++) if (mk[i] == mk[i-1]) m_tie = 1'b1;
  endtask

  task automatic do_run(input bit load, input logic [63:0] seed,
                        input logic [7:0] stall, input bit poke);
    int cyc;
    int k;
    int t;
    bit held;
    logic [IDX_W-1:0] held_idx;
    bit held_last;
    bit seen [N];
    if (load) begin
      @(negedge clk);
      seed_load = 1'b1;
      seed_value = seed;
      @(negedge clk);
      seed_load = 1'b0;
      m_state = (seed == 64'd0) ? SUBST : seed;
    end
    model_run();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R6", "busy after start", busy, 1);
    cyc = 1;
    while (!perm_valid) begin
      if (poke && cyc == 12) begin
        start = 1'b1;
        seed_load = 1'b1;
        seed_value = ~seed;
      end
      @(negedge clk);
      start = 1'b0;
      seed_load = 1'b0;
      cyc++;
      if (cyc > 5000) break;
    end
    if (ref_cycles < 0) ref_cycles = cyc;
    else chk(cyc == ref_cycles, poke ? "R7" : "R4", "cycles to first output",
             cyc, ref_cycles);
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    k = 0;
    t = 0;
    held = 1'b0;
    held_idx = '0;
    held_last = 1'b0;
    while (k < N && t < 2000) begin
      perm_ready = !stall[t % 8];
      t++;
      if (held) begin
        chk(perm_valid && perm_index == held_idx && perm_last == held_last,
            "R5", "hold under stall", perm_index, held_idx);
        held = 1'b0;
      end
      if (perm_valid && perm_ready) begin
        chk(int'(perm_index) == mi[k], poke ? "R7" : "R3", "index order",
            perm_index, mi[k]);
        chk(perm_last == (k == N-1), "R5", "last flag", perm_last, k == N-1);
        if (seen[perm_index]) chk(1'b0, "R3", "duplicate index", perm_index, -1);
        seen[perm_index] = 1'b1;
        k++;
      end else if (perm_valid) begin
        held = 1'b1;
        held_idx = perm_index;
        held_last = perm_last;
      end else begin
        chk(1'b0, "R5", "valid dropped mid-stream", 0, 1);
      end
      @(negedge clk);
    end
    perm_ready = 1'b0;
    chk(k == N, "R5", "handshake count", k, N);
    chk(done && !busy && !perm_valid, "R6", "completion state",
        {done, busy, perm_valid}, 3'b100);
    chk(tie_seen == m_tie, "R8", "tie flag", tie_seen, m_tie);
    @(negedge clk);
    chk(done == 1'b1, "R6", "done held", done, 1);
  endtask

  initial begin
    m_state = SUBST;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && tie_seen == 1'b0 && perm_valid == 1'b0,
        "R1", "reset outputs", {busy, done, tie_seen, perm_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && perm_valid == 1'b0, "R1", "idle after reset",
        {busy, perm_valid}, 0);

    for (int v = 0; v < NVEC; v++) do_run(1'b1, SEED_TAB[v], STALL_TAB[v], 1'b0);

    // R2: zero seed is substituted
    do_run(1'b1, 64'd0, 8'h24, 1'b0);
    // R2: state carried into the next run without reload
    do_run(1'b0, 64'd0, 8'h00, 1'b0);
    // R7: start and seed_load while busy have no effect
    do_run(1'b1, 64'hC0FF_EE00_1234_5678, 8'h10, 1'b1);
    // R2: the state after the poked run is the model's continuation
    do_run(1'b0, 64'd0, 8'h00, 1'b0);

    finish_all();
  end

endmodule